// File: doc/BRIEF.md
# PHY Management Register Bridge

This block gives host software a single 32-bit register through which it reads and writes the 16-bit management registers of an external Ethernet PHY. Software writes a register address, a direction bit and, for a write, a data word. The bridge then sends one serial management frame on the MDC/MDIO pins, and software polls the same register until the direction bit shows that the frame has finished.

The direction bit, bit 31, signals completion in opposite senses for the two directions. A write request carries a 1 in bit 31, and hardware lowers it to 0 when the frame has gone out. A read request carries a 0, and hardware raises it to 1 once bits 15:0 hold the data returned by the PHY. Only PHY address 1 can be reached. The clock for the management bus is made from the system clock by a divider whose ratio is a parameter. The bridge shares the bidirectional data line by way of a separate output-enable pin.

Top module: `mdio_reg_bridge`

## Requirements
- R1: After reset, `host_rdata` reads 0, `mdc` is low and `mdio_oe` is low.
- R2: A host write accepted while the bridge is idle appears on `host_rdata` on the next cycle: bit 31 is the flag as written, bits 20:16 are the register address, bits 15:0 are the data, and bits 30:21 read as zero.
- R3: A write request (bit 31 = 1) sends 64 bits, each sampled on an `mdc` rising edge, MSB first: 32 ones, start 01, opcode 01, PHY address 00001, the 5-bit register address, turnaround 10, and then the 16 data bits. `mdio_oe` is high for all 64 bits.
- R4: When a write frame ends, bit 31 drops to 0, and the address and data fields keep their values.
- R5: A read request (bit 31 = 0) sends 32 ones, start 01, opcode 10, PHY address 00001 and the register address as its first 46 bits. `mdio_oe` is low for the last 18 bits (the turnaround and the data).
- R6: When a read frame ends, bit 31 rises to 1 and bits 15:0 hold the 16 bits that the PHY drove on `mdio_i` during the data phase, the first bit received being bit 15.
- R7: A host write that arrives while a frame is in progress is ignored: `host_rdata` does not change, and the frame in progress keeps the values it started with.
- R8: `mdc` has a period of 2*CLK_DIV system clocks and gives exactly 64 rising edges per transaction. It stays low, and `mdio_oe` stays low, while the bridge is idle.
- R9: `mdio_o` and `mdio_oe` change only while `mdc` is low. They never change during an `mdc` high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for the access register |
| host_wdata | input | 32 | Host write data: flag, register address and data |
| host_rdata | output | 32 | Current contents of the access register |
| mdc | output | 1 | Management bus clock |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for the management data line |
| mdio_i | input | 1 | Management data received from the PHY |

## Verification
The checker watches several properties on every cycle: the register is left unchanged while a frame is in progress, the flag flips at the end of each frame, the written word is echoed on the cycle after an accepted write, and the bus clock and data pins stay quiet whenever the bridge is idle. It also checks on every cycle that the data pins never move during a high phase of `mdc`, which is the timing rule a PHY depends on. The exact content of the frames, the position of the released turnaround, the assembly of the read data and the measured `mdc` period depend on a PHY model seen from outside the bridge. The directed scenarios in the bench are the only place these are checked.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  localparam int FRAME_BITS = 64;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int TA_IDX     = 46;
  localparam int DATA_IDX   = 48;

  localparam logic [31:0] PREAMBLE = 32'hFFFF_FFFF;
  localparam logic [1:0]  SOF      = 2'b01;
  localparam logic [1:0]  OP_RD    = 2'b10;
  localparam logic [1:0]  OP_WR    = 2'b01;
  localparam logic [1:0]  TA_WR    = 2'b10;
  localparam logic [4:0]  PHY_ADDR = 5'd1;

  typedef struct packed {
    logic        flag;
    logic [9:0]  rsv;
    logic [4:0]  regad;
    logic [15:0] data;
  } acc_reg_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_tk,
  output logic fall_tk
);
  localparam int CW = $clog2(CLK_DIV) + 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap    = run && (cnt_q == CW'(CLK_DIV - 1));
  assign rise_tk = wrap && !mdc_q;
  assign fall_tk = wrap && mdc_q;
  assign mdc     = mdc_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        start_read,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  input  logic        rise_tk,
  input  logic        fall_tk,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic        rd_op,
  output logic [15:0] rd_data,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [FRAME_BITS-1:0] sh_q;
  logic [BIT_W-1:0]      bit_q;
  logic                  busy_q, rd_op_q, oe_q;
  logic [15:0]           rd_q;
  logic                  last;

  assign last    = (bit_q == BIT_W'(FRAME_BITS - 1));
  assign done    = busy_q && fall_tk && last;
  assign busy    = busy_q;
  assign rd_op   = rd_op_q;
  assign rd_data = rd_q;
  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign mdio_oe = oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '1;
      bit_q   <= '0;
      busy_q  <= 1'b0;
      rd_op_q <= 1'b0;
      oe_q    <= 1'b0;
      rd_q    <= '0;
    end else if (start && !busy_q) begin
      sh_q    <= start_read ?
                 {PREAMBLE, SOF, OP_RD, PHY_ADDR, reg_addr, 2'b11, 16'hFFFF} :
                 {PREAMBLE, SOF, OP_WR, PHY_ADDR, reg_addr, TA_WR, wr_data};
      bit_q   <= '0;
      busy_q  <= 1'b1;
      rd_op_q <= start_read;
      oe_q    <= 1'b1;
    end else if (busy_q) begin
      if (rise_tk && rd_op_q && (bit_q >= BIT_W'(DATA_IDX)))
        rd_q <= {rd_q[14:0], mdio_i};
      if (fall_tk) begin
        if (last) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b0;
          sh_q   <= '1;
        end else begin
          sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b1};
          bit_q <= bit_q + 1'b1;
          oe_q  <= !(rd_op_q && (bit_q >= BIT_W'(TA_IDX - 1)));
        end
      end
    end
  end
endmodule

// File: rtl/mdio_reg_bridge.sv
module mdio_reg_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  acc_reg_t    acc_q;
  acc_reg_t    wr_word;
  logic        busy, done, rd_op, rise_tk, fall_tk, accept;
  logic [15:0] rd_data;

  assign wr_word    = acc_reg_t'(host_wdata);
  assign accept     = host_wr && !busy;
  assign host_rdata = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (accept) begin
      acc_q.flag  <= wr_word.flag;
      acc_q.rsv   <= '0;
      acc_q.regad <= wr_word.regad;
      acc_q.data  <= wr_word.data;
    end else if (done) begin
      if (rd_op) begin
        acc_q.data <= rd_data;
        acc_q.flag <= 1'b1;
      end else begin
        acc_q.flag <= 1'b0;
      end
    end
  end

  mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
    .clk     (clk),
    .rst     (rst),
    .run     (busy),
    .mdc     (mdc),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk)
  );

  mdio_frame_engine u_eng (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .start_read (!wr_word.flag),
    .reg_addr   (wr_word.regad),
    .wr_data    (wr_word.data),
    .rise_tk    (rise_tk),
    .fall_tk    (fall_tk),
    .mdio_i     (mdio_i),
    .busy       (busy),
    .done       (done),
    .rd_op      (rd_op),
    .rd_data    (rd_data),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
  );
endmodule

// File: rtl/mdio_bridge_chk.sv
module mdio_bridge_chk (
  input logic        clk,
  input logic        rst,
  input logic        host_wr,
  input logic [31:0] host_wdata,
  input logic [31:0] host_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (host_rdata == 32'd0));

  assert_accept_echo_R2: assert property (@(posedge clk) disable iff (rst)
    $past(host_wr && !busy && !rst) |->
      (host_rdata == {$past(host_wdata[31]), 10'd0, $past(host_wdata[20:0])}));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    host_rdata[30:21] == 10'd0);

  // R4 and R6: the flag flips at the end of every frame
  assert_flag_flip_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (host_rdata[31] != $past(host_rdata[31])));

  assert_hold_while_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(host_rdata));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  assert_stable_high_R9: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mdio_reg_bridge mdio_bridge_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_wr    (host_wr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .busy       (busy)
);

// File: tb/test_mdio_reg_bridge.sv
`timescale 1ns/1ps
module test_mdio_reg_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int MDC_DIV    = 4;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic [63:0] cap_o, cap_oe;
  logic [15:0] phy_word = '0;
  int          edge_cnt = 0;
  realtime     t0 = 0, t1 = 0;

  mdio_reg_bridge #(.CLK_DIV(MDC_DIV)) i_mdio_reg_bridge (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // PHY model: capture on rising MDC, drive read data after the edge
  always @(posedge mdc) begin
    if (edge_cnt < 64) begin
      cap_o[63-edge_cnt]  = mdio_o;
      cap_oe[63-edge_cnt] = mdio_oe;
    end
    if (edge_cnt == 0) t0 = $realtime;
    if (edge_cnt == 1) t1 = $realtime;
    if (edge_cnt >= 47 && edge_cnt <= 62) mdio_i = phy_word[62-edge_cnt];
    edge_cnt++;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected finish earlier", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [31:0] w);
    @(negedge clk); host_wr = 1'b1; host_wdata = w;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic wait_flag(input logic want);
    for (int i = 0; i < 2000; i++) begin
      if (host_rdata[31] == want) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(host_rdata == 32'd0, "R1 rdata", host_rdata, 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_write(input logic [4:0] ra, input logic [15:0] d);
    logic [31:0] w = {1'b1, 10'h3FF, 5'd0, d} | {11'd0, ra, 16'd0};
    logic [63:0] exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd1, ra, 2'b10, d};
    edge_cnt = 0;
    host_write(w);
    chk(host_rdata == {1'b1, 10'd0, ra, d}, "R2 echo", host_rdata, {1'b1, 10'd0, ra, d});
    wait_flag(1'b0);
    chk(host_rdata == {1'b0, 10'd0, ra, d}, "R4 write done", host_rdata, {1'b0, 10'd0, ra, d});
    chk(cap_o == exp, "R3 write frame", cap_o, exp);
    chk(cap_oe == '1, "R3 write oe", cap_oe, '1);
    chk(edge_cnt == 64, "R8 edge count", edge_cnt, 64);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R8 idle pins", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_read(input logic [4:0] ra, input logic [15:0] pd);
    logic [45:0] exp = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd1, ra};
    edge_cnt = 0; mdio_i = 1'b1; phy_word = pd;
    host_write({1'b0, 10'd0, ra, 16'h5555});
    chk(host_rdata == {1'b0, 10'd0, ra, 16'h5555}, "R2 read echo", host_rdata, {1'b0, 10'd0, ra, 16'h5555});
    wait_flag(1'b1);
    chk(host_rdata == {1'b1, 10'd0, ra, pd}, "R6 read done", host_rdata, {1'b1, 10'd0, ra, pd});
    chk(cap_o[63:18] == exp, "R5 read header", cap_o[63:18], exp);
    chk(cap_oe == {46'h3FFF_FFFF_FFFF, 18'd0}, "R5 read oe", cap_oe, {46'h3FFF_FFFF_FFFF, 18'd0});
    chk(t1 - t0 == 2 * MDC_DIV * CLK_PERIOD, "R8 mdc period", 64'(int'(t1 - t0)), 2 * MDC_DIV * CLK_PERIOD);
    mdio_i = 1'b1;
  endtask

  task automatic t_busy_ignored();
    logic [63:0] exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd1, 5'd9, 2'b10, 16'hBEEF};
    edge_cnt = 0;
    host_write({1'b1, 10'd0, 5'd9, 16'hBEEF});
    repeat (100) @(negedge clk);
    host_write({1'b0, 10'd0, 5'd3, 16'h0123});
    chk(host_rdata == {1'b1, 10'd0, 5'd9, 16'hBEEF}, "R7 reg unchanged", host_rdata, {1'b1, 10'd0, 5'd9, 16'hBEEF});
    wait_flag(1'b0);
    chk(cap_o == exp, "R7 frame kept", cap_o, exp);
    chk(host_rdata == {1'b0, 10'd0, 5'd9, 16'hBEEF}, "R7 end state", host_rdata, {1'b0, 10'd0, 5'd9, 16'hBEEF});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write(5'd31, 16'h1234);
    t_write(5'd0, 16'hFFFF);
    t_read(5'd2, 16'hA5C3);
    t_read(5'd17, 16'h0001);
    t_busy_ignored();
    summary();
    $finish;
  end
endmodule